// File: doc/BRIEF.md
# Tri-Level Pull Control Receiver

This block decodes a single control wire that idles at a middle voltage and carries bits as short excursions above or below it. The analog front end gives two already-synchronized comparator outputs. `line_hi` means the wire is above the upper threshold and `line_lo` means it is below the lower one. When both are low, the wire is at the middle level. The receiver measures each excursion and each return to the middle in clock cycles. It turns valid symbols into bits and collects them into 40-bit frames. It then writes a signed frequency-pull setting that the oscillator control path uses.

A frame has three fields, most significant bit first: a 16-bit header, an 8-bit register selector and a 16-bit data word. The header must match a fixed pattern that carries the configured device-address nibble. Selector 0x06 writes the upper word of the pull setting. Selector 0x07 holds the seven low bits of a 23-bit setting and applies only in the two-frame mode. The receiver presents the active 23-bit two's-complement setting. It raises a one-cycle strobe each time that setting changes.

Three state machines form the block. The symbol stage has states SYM_MID, SYM_HIGH, SYM_LOW and SYM_BAD:
- SYM_MID goes to SYM_HIGH or SYM_LOW when an excursion starts.
- SYM_HIGH or SYM_LOW returns to SYM_MID when the wire returns to the middle. This emits a bit, or an error if the excursion was short.
- SYM_MID, SYM_HIGH or SYM_LOW goes to SYM_BAD on an illegal level. SYM_BAD returns to SYM_MID once the wire is at the middle.

The frame stage has states FRM_IDLE, FRM_COLLECT and FRM_EMIT:
- FRM_IDLE or FRM_EMIT goes to FRM_COLLECT on a bit.
- FRM_COLLECT goes to FRM_EMIT on the fortieth bit.
- FRM_EMIT goes back to FRM_IDLE after one cycle.
- Any state goes to FRM_IDLE on an abort.

The register stage has states REG_IDLE and REG_STAGED:
- REG_IDLE goes to REG_STAGED when a valid low part arrives.
- REG_STAGED goes back to REG_IDLE when the upper word commits.

Top module: `trilevel_pull_rx`

## Requirements
- R1: An excursion with `line_hi`=1 and then a return to the middle (both comparators 0) is a 1. An excursion with `line_lo`=1 and then a return to the middle is a 0. Forty such bits form a frame, first bit at frame bit 39. The frame layout is header = bits 39..24, selector = bits 23..16, data = bits 15..0.
- R2: A frame is accepted only if its header equals {8'hFA, cfg_dev_addr, 4'hA}. Any other header leaves `pull_value` unchanged and gives no strobe.
- R3: In mode 1 (`cfg_mode2`=0), an accepted selector-0x06 frame sets `pull_value` to {data, 7'b0}. The strobe is high in exactly the third clock cycle after the first cycle in which the middle level is sampled at the end of the frame's last bit.
- R4: In mode 2 (`cfg_mode2`=1), an accepted selector-0x07 frame with data[15:7]=0 stores data[6:0] as the staged low part. It does not change `pull_value` and gives no strobe.
- R5: In mode 2, an accepted selector-0x06 frame sets `pull_value` to {data, staged low part} and then clears the staging. Without a staged low part, the low seven bits are zero.
- R6: In mode 2, a selector-0x07 frame with any of data[15:7] set is rejected and leaves the staging as it was. In mode 1, every selector-0x07 frame is discarded.
- R7: A frame with a selector other than 0x06 or 0x07 is accepted but has no effect.
- R8: After reset, `pull_value` is 0 and `pull_update` is 0.
- R9: `pull_update` is a single-cycle pulse, raised only when the committed value differs from the previous one. Rewriting the current value gives no strobe.
- R10: Three conditions abort the frame in progress:
  - an excursion shorter than MIN_PULSE_CYC sampled cycles;
  - a direct jump between high and low;
  - both comparators asserted.
  After an abort, the next complete 40 bits form a new frame.
- R11: A middle phase shorter than MIN_MID_CYC cycles before an excursion aborts the frame in progress. That excursion becomes the first bit of a new frame.
- R12: A middle level held for IDLE_TIMEOUT_CYC cycles resets bit counting, so the next excursion is bit 39 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_hi | input | 1 | Synchronized above-upper-threshold comparator |
| line_lo | input | 1 | Synchronized below-lower-threshold comparator |
| cfg_mode2 | input | 1 | 0: single-frame updates, 1: two-frame updates |
| cfg_dev_addr | input | 4 | Device-address nibble expected in the header |
| pull_value | output | 23 | Active two's-complement pull setting |
| pull_update | output | 1 | One-cycle strobe when `pull_value` changes |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- a bit is only ever reported after the middle level was sampled;
- frame pulses are single cycles that follow a bit;
- aborts never produce a frame;
- a bad header or a low-part frame never strobes;
- the output holds whenever there is no strobe;
- mode-1 results carry zero low bits.

Other behaviour needs whole serial sequences, so only the bench scenarios show it:
- the exact strobe latency;
- two-frame staging and its clearing;
- rejection of a malformed low part;
- recovery from short pulses, short middles and illegal levels;
- realignment after an idle gap.

// File: rtl/tlr_pkg.sv
package tlr_pkg;

    localparam int unsigned FRAME_BITS = 40;
    localparam int unsigned HDR_BITS   = 16;
    localparam int unsigned SEL_BITS   = 8;
    localparam int unsigned DATA_BITS  = 16;
    localparam int unsigned LOW_BITS   = 7;
    localparam int unsigned PULL_BITS  = DATA_BITS + LOW_BITS;

    localparam logic [7:0] HDR_PREFIX = 8'hFA;
    localparam logic [3:0] HDR_SUFFIX = 4'hA;

    localparam logic [SEL_BITS-1:0] SEL_UPPER = 8'h06;
    localparam logic [SEL_BITS-1:0] SEL_LOWER = 8'h07;

    typedef enum logic [1:0] {
        LVL_MID,
        LVL_HIGH,
        LVL_LOW,
        LVL_BOTH
    } level_t;

    typedef enum logic [1:0] {
        SYM_MID,
        SYM_HIGH,
        SYM_LOW,
        SYM_BAD
    } sym_state_t;

    typedef enum logic [1:0] {
        FRM_IDLE,
        FRM_COLLECT,
        FRM_EMIT
    } frm_state_t;

    typedef enum logic {
        REG_IDLE,
        REG_STAGED
    } reg_state_t;

endpackage

// File: rtl/tlr_symbol.sv
module tlr_symbol #(
    parameter int unsigned MIN_PULSE_CYC    = 50,
    parameter int unsigned MIN_MID_CYC      = 50,
    parameter int unsigned IDLE_TIMEOUT_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_hi,
    input  logic line_lo,
    output logic bit_vld,
    output logic bit_val,
    output logic sym_err,
    output logic idle_rst
);
    import tlr_pkg::*;

    localparam int unsigned TOP_A   = (MIN_PULSE_CYC > MIN_MID_CYC) ? MIN_PULSE_CYC : MIN_MID_CYC;
    localparam int unsigned CNT_TOP = (TOP_A > IDLE_TIMEOUT_CYC) ? TOP_A : IDLE_TIMEOUT_CYC;
    localparam int unsigned CNT_W   = $clog2(CNT_TOP + 1);
    localparam logic [CNT_W-1:0] P_MIN    = CNT_W'(MIN_PULSE_CYC);
    localparam logic [CNT_W-1:0] M_MIN    = CNT_W'(MIN_MID_CYC);
    localparam logic [CNT_W-1:0] IDLE_TOP = CNT_W'(IDLE_TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] CNT_ALL  = CNT_W'(CNT_TOP);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    level_t           lvl;
    level_t           want_lvl;
    sym_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ev_bit, ev_val, ev_err, ev_idle;

    always_comb begin
        if (line_hi && line_lo) lvl = LVL_BOTH;
        else if (line_hi)       lvl = LVL_HIGH;
        else if (line_lo)       lvl = LVL_LOW;
        else                    lvl = LVL_MID;
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        ev_bit   = 1'b0;
        ev_val   = 1'b0;
        ev_err   = 1'b0;
        ev_idle  = 1'b0;
        want_lvl = (state_q == SYM_HIGH) ? LVL_HIGH : LVL_LOW;
        unique case (state_q)
            SYM_MID: begin
                unique case (lvl)
                    LVL_MID: begin
                        if (cnt_q < IDLE_TOP) begin
                            cnt_d = cnt_q + ONE;
                            if (cnt_q == IDLE_TOP - ONE) ev_idle = 1'b1;
                        end
                    end
                    LVL_HIGH: begin
                        state_d = SYM_HIGH;
                        cnt_d   = ONE;
                        ev_err  = (cnt_q < M_MIN);
                    end
                    LVL_LOW: begin
                        state_d = SYM_LOW;
                        cnt_d   = ONE;
                        ev_err  = (cnt_q < M_MIN);
                    end
                    LVL_BOTH: begin
                        state_d = SYM_BAD;
                        ev_err  = 1'b1;
                    end
                endcase
            end
            SYM_HIGH, SYM_LOW: begin
                if (lvl == want_lvl) begin
                    if (cnt_q != CNT_ALL) cnt_d = cnt_q + ONE;
                end else if (lvl == LVL_MID) begin
                    state_d = SYM_MID;
                    cnt_d   = ONE;
                    if (cnt_q >= P_MIN) begin
                        ev_bit = 1'b1;
                        ev_val = (state_q == SYM_HIGH);
                    end else begin
                        ev_err = 1'b1;
                    end
                end else begin
                    state_d = SYM_BAD;
                    ev_err  = 1'b1;
                end
            end
            SYM_BAD: begin
                if (lvl == LVL_MID) begin
                    state_d = SYM_MID;
                    cnt_d   = ONE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYM_MID;
            cnt_q   <= IDLE_TOP;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_vld  <= 1'b0;
            bit_val  <= 1'b0;
            sym_err  <= 1'b0;
            idle_rst <= 1'b0;
        end else begin
            bit_vld  <= ev_bit;
            bit_val  <= ev_val;
            sym_err  <= ev_err;
            idle_rst <= ev_idle;
        end
    end

    AST_BIT_AFTER_MID: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(!line_hi && !line_lo)); // R1
    AST_BIT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld); // R1
    AST_IDLE_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
        idle_rst |-> $past(!line_hi && !line_lo)); // R12

endmodule

// File: rtl/tlr_frame.sv
module tlr_frame (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bit_vld,
    input  logic                            bit_val,
    input  logic                            abort,
    output logic                            frm_vld,
    output logic [tlr_pkg::FRAME_BITS-1:0]  frm_word
);
    import tlr_pkg::*;

    localparam int unsigned FCNT_W = $clog2(FRAME_BITS);
    localparam logic [FCNT_W-1:0] LAST = FCNT_W'(FRAME_BITS - 1);

    frm_state_t            state_q, state_d;
    logic [FCNT_W-1:0]     cnt_q, cnt_d;
    logic [FRAME_BITS-1:0] shreg_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (abort) begin
            state_d = FRM_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FRM_IDLE, FRM_COLLECT, FRM_EMIT: begin
                    if (bit_vld) begin
                        if (cnt_q == LAST) begin
                            state_d = FRM_EMIT;
                            cnt_d   = '0;
                        end else begin
                            state_d = FRM_COLLECT;
                            cnt_d   = cnt_q + FCNT_W'(1);
                        end
                    end else if (state_q == FRM_EMIT) begin
                        state_d = FRM_IDLE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FRM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 shreg_q <= '0;
        else if (bit_vld && !abort) shreg_q <= {shreg_q[FRAME_BITS-2:0], bit_val};
    end

    // outputs
    always_comb begin
        frm_vld  = (state_q == FRM_EMIT);
        frm_word = shreg_q;
    end

    AST_FRAME_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> $past(bit_vld)); // R1
    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld); // R1
    AST_ABORT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !frm_vld); // R10

endmodule

// File: rtl/tlr_pull_regs.sv
module tlr_pull_regs (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frm_vld,
    input  logic [tlr_pkg::FRAME_BITS-1:0] frm_word,
    input  logic                           cfg_mode2,
    input  logic [3:0]                     cfg_dev_addr,
    output logic [tlr_pkg::PULL_BITS-1:0]  pull_value,
    output logic                           pull_update
);
    import tlr_pkg::*;

    logic [HDR_BITS-1:0]  hdr_w;
    logic [SEL_BITS-1:0]  sel_w;
    logic [DATA_BITS-1:0] data_w;
    logic                 hdr_ok;

    reg_state_t           state_q, state_d;
    logic [LOW_BITS-1:0]  low_q, low_d;
    logic                 commit;
    logic [PULL_BITS-1:0] commit_val;
    logic [PULL_BITS-1:0] pull_q;
    logic                 upd_q;

    always_comb begin
        hdr_w  = frm_word[FRAME_BITS-1 -: HDR_BITS];
        sel_w  = frm_word[DATA_BITS +: SEL_BITS];
        data_w = frm_word[DATA_BITS-1:0];
        hdr_ok = (hdr_w == {HDR_PREFIX, cfg_dev_addr, HDR_SUFFIX});
    end

    always_comb begin
        state_d    = state_q;
        low_d      = low_q;
        commit     = 1'b0;
        commit_val = pull_q;
        if (frm_vld && hdr_ok) begin
            if (sel_w == SEL_UPPER) begin
                commit = 1'b1;
                unique case (state_q)
                    REG_IDLE:   commit_val = {data_w, {LOW_BITS{1'b0}}};
                    REG_STAGED: commit_val = {data_w, (cfg_mode2 ? low_q : {LOW_BITS{1'b0}})};
                endcase
                state_d = REG_IDLE;
                low_d   = '0;
            end else if (sel_w == SEL_LOWER && cfg_mode2
                         && data_w[DATA_BITS-1:LOW_BITS] == '0) begin
                state_d = REG_STAGED;
                low_d   = data_w[LOW_BITS-1:0];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REG_IDLE;
            low_q   <= '0;
        end else begin
            state_q <= state_d;
            low_q   <= low_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            if (commit) pull_q <= commit_val;
            upd_q <= commit && (commit_val != pull_q);
        end
    end

    assign pull_value  = pull_q;
    assign pull_update = upd_q;

    AST_STROBE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pull_update |-> (pull_value != $past(pull_value))); // R9
    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_update |-> $stable(pull_value)); // R9
    AST_MODE1_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_update && !$past(cfg_mode2)) |-> (pull_value[LOW_BITS-1:0] == '0)); // R3
    AST_LOW_PART_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && hdr_ok && sel_w == SEL_LOWER) |=> !pull_update); // R4
    AST_BAD_HEADER_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && !hdr_ok) |=> !pull_update); // R2

endmodule

// File: rtl/trilevel_pull_rx.sv
module trilevel_pull_rx #(
    parameter int unsigned MIN_PULSE_CYC    = 50,
    parameter int unsigned MIN_MID_CYC      = 50,
    parameter int unsigned IDLE_TIMEOUT_CYC = 400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        cfg_mode2,
    input  logic [3:0]  cfg_dev_addr,
    output logic [22:0] pull_value,
    output logic        pull_update
);
    import tlr_pkg::*;

    logic                  bit_vld, bit_val, sym_err, idle_rst;
    logic                  frm_vld;
    logic [FRAME_BITS-1:0] frm_word;
    logic                  abort;

    assign abort = sym_err | idle_rst;

    tlr_symbol #(
        .MIN_PULSE_CYC    (MIN_PULSE_CYC),
        .MIN_MID_CYC      (MIN_MID_CYC),
        .IDLE_TIMEOUT_CYC (IDLE_TIMEOUT_CYC)
    ) i_symbol (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_hi  (line_hi),
        .line_lo  (line_lo),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .sym_err  (sym_err),
        .idle_rst (idle_rst)
    );

    tlr_frame i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .abort    (abort),
        .frm_vld  (frm_vld),
        .frm_word (frm_word)
    );

    tlr_pull_regs i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_vld      (frm_vld),
        .frm_word     (frm_word),
        .cfg_mode2    (cfg_mode2),
        .cfg_dev_addr (cfg_dev_addr),
        .pull_value   (pull_value),
        .pull_update  (pull_update)
    );

endmodule

// File: tb/test_trilevel_pull_rx.sv
module test_trilevel_pull_rx;

    localparam int CLK_PERIOD = 10;
    localparam int P_CYC      = 52;
    localparam int M_CYC      = 52;
    localparam int IDLE_WAIT  = 450;
    localparam int WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_hi = 1'b0;
    logic        line_lo = 1'b0;
    logic        cfg_mode2 = 1'b0;
    logic [3:0]  cfg_dev_addr = 4'h0;
    logic [22:0] pull_value;
    logic        pull_update;

    int n_chk = 0;
    int n_bad = 0;
    int upd_cnt = 0;
    int upd_at = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trilevel_pull_rx i_trilevel_pull_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_hi      (line_hi),
        .line_lo      (line_lo),
        .cfg_mode2    (cfg_mode2),
        .cfg_dev_addr (cfg_dev_addr),
        .pull_value   (pull_value),
        .pull_update  (pull_update)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic hi, input logic lo, input int n);
        line_hi = hi;
        line_lo = lo;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (pull_update) begin
                upd_cnt++;
                upd_at = i;
            end
        end
    endtask

    task automatic send_sym(input logic b, input int p, input int m);
        hold(b, ~b, p);
        hold(1'b0, 1'b0, m);
    endtask

    task automatic send_frame(input logic [15:0] hdr, input logic [7:0] sel, input logic [15:0] data);
        logic [39:0] w;
        w = {hdr, sel, data};
        upd_cnt = 0;
        upd_at = 0;
        for (int i = 39; i >= 0; i--) send_sym(w[i], P_CYC, M_CYC);
    endtask

    task automatic expect_update(input string tag, input logic [22:0] exp);
        chk(upd_cnt == 1, {tag, " strobe count"}, upd_cnt, 1);
        chk(upd_at == 3, {tag, " strobe cycle"}, upd_at, 3);
        chk(pull_value == exp, {tag, " value"}, pull_value, exp);
    endtask

    task automatic expect_quiet(input string tag, input logic [22:0] exp);
        chk(upd_cnt == 0, {tag, " no strobe"}, upd_cnt, 0);
        chk(pull_value == exp, {tag, " value held"}, pull_value, exp);
    endtask

    task automatic t_reset();
        chk(pull_value == 23'd0, "R8 reset value", pull_value, 0);
        chk(pull_update == 1'b0, "R8 reset strobe", pull_update, 0);
    endtask

    task automatic t_mode1();
        cfg_mode2 = 1'b0;
        send_frame(16'hFA0A, 8'h06, 16'h139F);
        expect_update("R3 R1 mode1 positive", 23'h09CF80);
        send_frame(16'hFA0A, 8'h06, 16'hBD98);
        expect_update("R3 R1 mode1 negative", 23'h5ECC00);
    endtask

    task automatic t_same_value();
        send_frame(16'hFA0A, 8'h06, 16'hBD98);
        expect_quiet("R9 rewrite same", 23'h5ECC00);
    endtask

    task automatic t_mode1_low_discarded();
        send_frame(16'hFA0A, 8'h07, 16'h000A);
        expect_quiet("R6 mode1 low frame", 23'h5ECC00);
        send_frame(16'hFA0A, 8'h06, 16'h0001);
        expect_update("R6 mode1 no staging", 23'h000080);
    endtask

    task automatic t_mode2_pair();
        cfg_mode2 = 1'b1;
        send_frame(16'hFA0A, 8'h07, 16'h000A);
        expect_quiet("R4 stage low", 23'h000080);
        send_frame(16'hFA0A, 8'h06, 16'h139F);
        expect_update("R5 commit pair", 23'h09CF8A);
        send_frame(16'hFA0A, 8'h07, 16'h000B);
        expect_quiet("R4 stage low negative", 23'h09CF8A);
        send_frame(16'hFA0A, 8'h06, 16'hBD98);
        expect_update("R5 commit negative pair", 23'h5ECC0B);
    endtask

    task automatic t_mode2_reject();
        send_frame(16'hFA0A, 8'h07, 16'h0100);
        expect_quiet("R6 reject low", 23'h5ECC0B);
        send_frame(16'hFA0A, 8'h06, 16'h1000);
        expect_update("R5 R6 lone upper", 23'h080000);
    endtask

    task automatic t_other_sel();
        send_frame(16'hFA0A, 8'h05, 16'h7777);
        expect_quiet("R7 other selector", 23'h080000);
    endtask

    task automatic t_header();
        send_frame(16'hFA1A, 8'h06, 16'h2222);
        expect_quiet("R2 wrong address nibble", 23'h080000);
        send_frame(16'hFB0A, 8'h06, 16'h2222);
        expect_quiet("R2 wrong prefix", 23'h080000);
        cfg_dev_addr = 4'h5;
        hold(1'b0, 1'b0, M_CYC);
        send_frame(16'hFA5A, 8'h06, 16'h2222);
        expect_update("R2 matching nibble", 23'h111100);
        cfg_dev_addr = 4'h0;
        hold(1'b0, 1'b0, M_CYC);
    endtask

    task automatic t_short_pulse();
        for (int i = 0; i < 5; i++) send_sym(1'b1, P_CYC, M_CYC);
        send_sym(1'b1, 10, M_CYC);
        send_frame(16'hFA0A, 8'h06, 16'h0F0F);
        expect_update("R10 short pulse recovery", 23'h078780);
        for (int i = 0; i < 7; i++) send_sym(1'b0, P_CYC, M_CYC);
        hold(1'b1, 1'b1, 5);
        hold(1'b0, 1'b0, M_CYC);
        send_frame(16'hFA0A, 8'h06, 16'h7001);
        expect_update("R10 both levels recovery", 23'h380080);
    endtask

    task automatic t_short_mid();
        logic [39:0] w;
        w = {16'hFA0A, 8'h06, 16'h4444};
        upd_cnt = 0;
        for (int i = 39; i >= 0; i--) send_sym(w[i], P_CYC, (i == 29) ? 10 : M_CYC);
        hold(1'b0, 1'b0, IDLE_WAIT);
        expect_quiet("R11 short middle", 23'h380080);
    endtask

    task automatic t_idle_realign();
        for (int i = 0; i < 12; i++) send_sym(i[0], P_CYC, M_CYC);
        hold(1'b0, 1'b0, IDLE_WAIT);
        send_frame(16'hFA0A, 8'h06, 16'h1234);
        expect_update("R12 idle realign", 23'h091A00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_mode1();
        t_same_value();
        t_mode1_low_discarded();
        t_mode2_pair();
        t_mode2_reject();
        t_other_sel();
        t_header();
        t_short_pulse();
        t_short_mid();
        t_idle_realign();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=0x%0h exp=0x%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule